// File: doc/BRIEF.md
# Serial Port Register Front-End

This block sits between a host's simple register strobe interface and a bit-level serial engine. The host writes outgoing bytes into a 64-entry transmit queue and pulls incoming bytes from a 64-entry receive queue. Separate word locations hold the control bits, a read-only status word, two queue-level thresholds and a baud setting. The baud setting is passed straight through to the engine.

The engine drains the transmit queue with a take strobe and fills the receive queue with a push strobe. It also reports parity and framing faults as one-cycle pulses. The block keeps those faults, plus host attempts to overfill the transmit queue, as sticky flags. One interrupt line combines a receive-level condition and a transmit-level condition, and each condition has its own enable.

The host addresses words by byte address, with the low two bits ignored. Word 0 (0x00) is transmit data, word 1 (0x04) receive data, word 2 (0x08) control, word 3 (0x0C) status, word 4 (0x10) thresholds and word 5 (0x14) baud. All other words read as zero and ignore writes.

Top module: `uart_regfile`

## Requirements
- R1: After reset every control bit is zero, both queues are empty, all sticky flags are clear, `irq` and `tx_valid` are low, and status reads with only bit 20 (receive empty) and bit 22 (transmit empty) set.
- R2: A write to 0x00 appends `bus_wdata[7:0]` to the transmit queue. `tx_valid` is high only when the queue holds data and control bit 12 (transmit enable) is set. `tx_byte` presents bytes in write order, and a `tx_take` while `tx_valid` is high removes the oldest one.
- R3: The transmit queue holds 64 bytes, and status bit 21 is set when it is full. A write to 0x00 while it is full discards the byte and sets sticky status bit 18.
- R4: With control bit 13 (receive enable) set, each `rx_push` appends `rx_byte` to the receive queue. A read of 0x04 returns the oldest byte in bits 7:0 and removes it. While the queue is empty, the read returns zero and leaves the queue unchanged. Pushes are ignored while bit 13 is clear or while the queue already holds 64 bytes.
- R5: An `rx_parity_err` pulse sets sticky status bit 16 and an `rx_frame_err` pulse sets sticky status bit 17. Both stay set until cleared.
- R6: While control bit 24 (error clear) holds one, status bits 16, 17 and 18 read zero and cannot set. They can set again only after the host writes bit 24 back to zero.
- R7: While control bit 22 is one, the transmit queue is held empty and accepts no writes. While control bit 23 is one, the receive queue is held empty and accepts no pushes.
- R8: Status bit 25 follows `tx_shift_busy`. The transmitter is fully drained when bit 22 reads one and bit 25 reads zero.
- R9: `irq` is high while control bit 27 is set and the receive queue count is greater than or equal to threshold bits 7:0.
- R10: `irq` is high while control bit 28 is set and the transmit queue count is less than or equal to threshold bits 15:8. Otherwise `irq` is low, apart from the R9 term.
- R11: Control reads back only bits 12, 13, 22, 23, 24, 27 and 28, and all other bits read zero. The threshold word reads back bits 15:0. The baud word reads back bits 23:0, and `baud_cfg` carries the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit byte available to the engine |
| tx_take | input | 1 | Engine consumes `tx_byte` |
| tx_shift_busy | input | 1 | Engine shifter still sending |
| rx_byte | input | 8 | Received byte from the engine |
| rx_push | input | 1 | Engine delivers `rx_byte` |
| rx_parity_err | input | 1 | Parity fault pulse |
| rx_frame_err | input | 1 | Framing fault pulse |
| tx_enable | output | 1 | Control bit 12 to the engine |
| rx_enable | output | 1 | Control bit 13 to the engine |
| baud_cfg | output | 24 | Baud word to the engine |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench builds the block with its default parameters: queues 64 deep, 8-bit thresholds and a 24-bit baud word. With 64 entries, both queues fill to the full boundary within a few hundred cycles, so overfill rejection and the write-error flag are reached both by directed steps and by the biased random mix. The 8-bit thresholds can exceed the largest count. Random threshold values up to 70 therefore cover levels that never trigger, levels that always trigger and levels that cross as the queues fill and drain.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

    // word indices (byte offset / 4)
    localparam int unsigned W_TXDATA = 0;
    localparam int unsigned W_RXDATA = 1;
    localparam int unsigned W_CTRL   = 2;
    localparam int unsigned W_STAT   = 3;
    localparam int unsigned W_LEVEL  = 4;
    localparam int unsigned W_BAUD   = 5;

    // control bit positions
    localparam int unsigned CB_TX_EN  = 12;
    localparam int unsigned CB_RX_EN  = 13;
    localparam int unsigned CB_TX_RST = 22;
    localparam int unsigned CB_RX_RST = 23;
    localparam int unsigned CB_CLR    = 24;
    localparam int unsigned CB_RX_IE  = 27;
    localparam int unsigned CB_TX_IE  = 28;

    // status bit positions
    localparam int unsigned SB_PAR   = 16;
    localparam int unsigned SB_FRM   = 17;
    localparam int unsigned SB_WERR  = 18;
    localparam int unsigned SB_RXE   = 20;
    localparam int unsigned SB_TXF   = 21;
    localparam int unsigned SB_TXE   = 22;
    localparam int unsigned SB_BUSY  = 25;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic tx_rst;
        logic rx_rst;
        logic err_clr;
        logic rx_ie;
        logic tx_ie;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.tx_en   = w[CB_TX_EN];
        c.rx_en   = w[CB_RX_EN];
        c.tx_rst  = w[CB_TX_RST];
        c.rx_rst  = w[CB_RX_RST];
        c.err_clr = w[CB_CLR];
        c.rx_ie   = w[CB_RX_IE];
        c.tx_ie   = w[CB_TX_IE];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CB_TX_EN]  = c.tx_en;
        w[CB_RX_EN]  = c.rx_en;
        w[CB_TX_RST] = c.tx_rst;
        w[CB_RX_RST] = c.rx_rst;
        w[CB_CLR]    = c.err_clr;
        w[CB_RX_IE]  = c.rx_ie;
        w[CB_TX_IE]  = c.tx_ie;
        return w;
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
    assign dout  = mem_q[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = ptr_inc(st_q.wp);
            if (do_pop)  st_d.rp = ptr_inc(st_q.rp);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= din;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int unsigned CW    = 7,
    parameter int unsigned THR_W = 8,
    localparam int unsigned MW   = (CW > THR_W) ? CW : THR_W
) (
    input  logic [CW-1:0]    rx_count,
    input  logic [CW-1:0]    tx_count,
    input  logic [THR_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_level,
    input  logic             rx_ie,
    input  logic             tx_ie,
    output logic             irq
);
    logic rx_hit, tx_hit;

    always_comb begin
        rx_hit = rx_ie && (MW'(rx_count) >= MW'(rx_level));
        tx_hit = tx_ie && (MW'(tx_count) <= MW'(tx_level));
        irq    = rx_hit || tx_hit;
    end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regfile_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned BAUD_W     = 24,
    parameter int unsigned THR_W      = 8,
    localparam int unsigned IDX_W     = ADDR_W - 2,
    localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic              tx_shift_busy,
    input  logic [7:0]        rx_byte,
    input  logic              rx_push,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic [BAUD_W-1:0] baud_cfg,
    output logic              irq
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [THR_W-1:0]  rx_lvl;
        logic [THR_W-1:0]  tx_lvl;
        logic [BAUD_W-1:0] baud;
        logic              pe;
        logic              fe;
        logic              we;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [IDX_W-1:0] idx;
    logic             wr_tx, rd_rx, tx_pop, rx_acc;
    logic [7:0]       rx_dout;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [31:0]      stat_w;
    logic             unused_bits;

    assign idx    = bus_addr[ADDR_W-1:2];
    assign wr_tx  = bus_wr && (idx == IDX_W'(W_TXDATA));
    assign rd_rx  = bus_rd && (idx == IDX_W'(W_RXDATA));
    assign tx_valid = !tx_empty && regs_q.ctrl.tx_en;
    assign tx_pop = tx_take && tx_valid;
    assign rx_acc = rx_push && regs_q.ctrl.rx_en;
    assign unused_bits = ^{bus_addr[1:0], rx_full};

    uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(regs_q.ctrl.tx_rst),
        .push(wr_tx), .din(bus_wdata[7:0]), .pop(tx_pop),
        .dout(tx_byte), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(regs_q.ctrl.rx_rst),
        .push(rx_acc), .din(rx_byte), .pop(rd_rx),
        .dout(rx_dout), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    uart_irq_gen #(.CW(CW), .THR_W(THR_W)) irq_i (
        .rx_count(rx_cnt), .tx_count(tx_cnt),
        .rx_level(regs_q.rx_lvl), .tx_level(regs_q.tx_lvl),
        .rx_ie(regs_q.ctrl.rx_ie), .tx_ie(regs_q.ctrl.tx_ie),
        .irq(irq)
    );

    // next-state of the register set
    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (idx)
                IDX_W'(W_CTRL):  regs_d.ctrl = word_to_ctrl(bus_wdata);
                IDX_W'(W_LEVEL): begin
                    regs_d.rx_lvl = bus_wdata[THR_W-1:0];
                    regs_d.tx_lvl = bus_wdata[2*THR_W-1:THR_W];
                end
                IDX_W'(W_BAUD):  regs_d.baud = bus_wdata[BAUD_W-1:0];
                default: ;
            endcase
        end
        if (regs_q.ctrl.err_clr) begin
            regs_d.pe = 1'b0;
            regs_d.fe = 1'b0;
            regs_d.we = 1'b0;
        end else begin
            regs_d.pe = regs_q.pe | rx_parity_err;
            regs_d.fe = regs_q.fe | rx_frame_err;
            regs_d.we = regs_q.we | (wr_tx && tx_full);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read path
    always_comb begin
        stat_w          = '0;
        stat_w[SB_PAR]  = regs_q.pe;
        stat_w[SB_FRM]  = regs_q.fe;
        stat_w[SB_WERR] = regs_q.we;
        stat_w[SB_RXE]  = rx_empty;
        stat_w[SB_TXF]  = tx_full;
        stat_w[SB_TXE]  = tx_empty;
        stat_w[SB_BUSY] = tx_shift_busy;

        bus_rdata = '0;
        case (idx)
            IDX_W'(W_RXDATA): if (!rx_empty) bus_rdata[7:0] = rx_dout;
            IDX_W'(W_CTRL):   bus_rdata = ctrl_to_word(regs_q.ctrl);
            IDX_W'(W_STAT):   bus_rdata = stat_w;
            IDX_W'(W_LEVEL):  bus_rdata[2*THR_W-1:0] = {regs_q.tx_lvl, regs_q.rx_lvl};
            IDX_W'(W_BAUD):   bus_rdata[BAUD_W-1:0] = regs_q.baud;
            default: ;
        endcase
    end

    assign tx_enable = regs_q.ctrl.tx_en;
    assign rx_enable = regs_q.ctrl.rx_en;
    assign baud_cfg  = regs_q.baud;

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctrl.err_clr |=> !(regs_q.pe || regs_q.fe || regs_q.we));

    // R3
    wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full && !regs_q.ctrl.err_clr) |=> regs_q.we);

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty) |-> (bus_rdata == 32'd0));

    // R5
    sticky_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.pe && !regs_q.ctrl.err_clr) |=> regs_q.pe);

    // R9
    rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl.rx_ie && (THR_W'(rx_cnt) >= regs_q.rx_lvl)) |-> irq);

    // R2
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !tx_valid);

endmodule

// File: tb/uart_regfile_tb_top.sv
module uart_regfile_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0] tx_byte, rx_byte = '0;
    logic tx_valid, tx_take = 0, tx_shift_busy = 0;
    logic rx_push = 0, rx_parity_err = 0, rx_frame_err = 0;
    logic tx_enable, rx_enable, irq;
    logic [23:0] baud_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
        .tx_shift_busy(tx_shift_busy), .rx_byte(rx_byte), .rx_push(rx_push),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .baud_cfg(baud_cfg), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    logic [7:0] mtx[$], mrx[$];
    logic m_txen, m_rxen, m_txrst, m_rxrst, m_clr, m_rie, m_tie;
    logic [7:0] m_rthr, m_tthr;
    logic m_pe, m_fe, m_we;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = '0;
        s[16] = m_pe; s[17] = m_fe; s[18] = m_we;
        s[20] = (mrx.size() == 0);
        s[21] = (mtx.size() == 64);
        s[22] = (mtx.size() == 0);
        s[25] = tx_shift_busy;
        return s;
    endfunction

    function automatic logic exp_irq();
        return (m_rie && (mrx.size() >= int'(m_rthr))) ||
               (m_tie && (mtx.size() <= int'(m_tthr)));
    endfunction

    task automatic bus_write(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(w * 4); bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(w * 4); bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic set_ctrl(input logic [31:0] w);
        bus_write(2, w);
        m_txen = w[12]; m_rxen = w[13]; m_txrst = w[22]; m_rxrst = w[23];
        m_clr = w[24]; m_rie = w[27]; m_tie = w[28];
        if (m_txrst) mtx.delete();
        if (m_rxrst) mrx.delete();
        if (m_clr) begin m_pe = 0; m_fe = 0; m_we = 0; end
    endtask

    function automatic logic [31:0] cw(input logic te, re, tr, rr, cl, ri, ti);
        logic [31:0] w = '0;
        w[12] = te; w[13] = re; w[22] = tr; w[23] = rr; w[24] = cl; w[27] = ri; w[28] = ti;
        return w;
    endfunction

    task automatic set_thr(input logic [7:0] r, input logic [7:0] t);
        bus_write(4, {16'd0, t, r});
        m_rthr = r; m_tthr = t;
    endtask

    task automatic tx_write(input logic [7:0] b);
        bus_write(0, {24'd0, b});
        if (!m_txrst) begin
            if (mtx.size() == 64) begin
                if (!m_clr) m_we = 1;
            end else mtx.push_back(b);
        end
    endtask

    task automatic engine_take(input string req);
        logic ev;
        @(negedge clk);
        #1;
        ev = m_txen && (mtx.size() > 0);
        chk({req, " tx_valid"}, {31'd0, tx_valid}, {31'd0, ev});
        if (ev) chk({req, " tx_byte"}, {24'd0, tx_byte}, {24'd0, mtx[0]});
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
        if (ev) void'(mtx.pop_front());
    endtask

    task automatic engine_push(input logic [7:0] b, input logic pe, input logic fe);
        @(negedge clk);
        rx_byte = b; rx_push = 1; rx_parity_err = pe; rx_frame_err = fe;
        @(negedge clk);
        rx_push = 0; rx_parity_err = 0; rx_frame_err = 0;
        if (m_rxen && !m_rxrst && mrx.size() < 64) mrx.push_back(b);
        if (!m_clr) begin m_pe |= pe; m_fe |= fe; end
    endtask

    task automatic rx_read(input string req);
        logic [31:0] d, e;
        e = (mrx.size() > 0) ? {24'd0, mrx[0]} : 32'd0;
        bus_read(1, d);
        chk(req, d, e);
        if (mrx.size() > 0) void'(mrx.pop_front());
    endtask

    task automatic stat_check(input string req);
        logic [31:0] d;
        bus_read(3, d);
        chk(req, d, exp_stat());
    endtask

    task automatic irq_check(input string req);
        #1 chk(req, {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        m_txen = 0; m_rxen = 0; m_txrst = 0; m_rxrst = 0; m_clr = 0; m_rie = 0; m_tie = 0;
        m_rthr = 0; m_tthr = 0; m_pe = 0; m_fe = 0; m_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        stat_check("R1 status");
        bus_read(2, d); chk("R1 ctrl", d, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

        // R11 readback
        bus_write(2, 32'hFFFF_FFFF);
        bus_read(2, d); chk("R11 ctrl mask", d, 32'h19C0_3000);
        set_ctrl(32'd0);
        set_thr(8'h3C, 8'hA5);
        bus_read(4, d); chk("R11 level", d, 32'h0000_A53C);
        bus_write(5, 32'hFFFF_FFFF);
        bus_read(5, d); chk("R11 baud", d, 32'h00FF_FFFF);
        chk("R11 baud_cfg", {8'd0, baud_cfg}, 32'h00FF_FFFF);
        set_thr(8'd0, 8'd0);

        // R2 gating and order
        tx_write(8'h11); tx_write(8'h22); tx_write(8'h33);
        engine_take("R2 disabled");
        set_ctrl(cw(1, 0, 0, 0, 0, 0, 0));
        for (int i = 0; i < 4; i++) engine_take("R2 order");

        // R3 fill and overflow
        for (int i = 0; i < 64; i++) tx_write(8'(i + 8'h40));
        stat_check("R3 full");
        tx_write(8'hEE);
        stat_check("R3 write error");
        for (int i = 0; i < 65; i++) engine_take("R3 discarded byte");

        // R6 clear held
        set_ctrl(cw(1, 0, 0, 0, 1, 0, 0));
        stat_check("R6 cleared");
        engine_push(8'h00, 1, 1);
        stat_check("R6 held");
        set_ctrl(cw(1, 0, 0, 0, 0, 0, 0));
        engine_push(8'h00, 1, 0);
        stat_check("R6 relatch R5 parity");
        engine_push(8'h00, 0, 1);
        stat_check("R5 frame");
        set_ctrl(cw(1, 1, 0, 0, 1, 0, 0));
        set_ctrl(cw(1, 1, 0, 0, 0, 0, 0));

        // R4 receive path
        engine_push(8'hA1, 0, 0); engine_push(8'hB2, 0, 0);
        rx_read("R4 first"); rx_read("R4 second"); rx_read("R4 empty zero");
        engine_push(8'hC3, 0, 0);
        rx_read("R4 after empty");

        // R7 queue resets
        engine_push(8'h01, 0, 0); engine_push(8'h02, 0, 0); tx_write(8'h55);
        set_ctrl(cw(1, 1, 1, 1, 0, 0, 0));
        engine_push(8'h03, 0, 0); tx_write(8'h66);
        stat_check("R7 held empty");
        set_ctrl(cw(1, 1, 0, 0, 0, 0, 0));
        rx_read("R7 rx stays empty");

        // R8 busy
        @(negedge clk); tx_shift_busy = 1;
        stat_check("R8 busy");
        @(negedge clk); tx_shift_busy = 0;
        stat_check("R8 drained");

        // R9 / R10 directed
        set_thr(8'd3, 8'd1);
        set_ctrl(cw(0, 1, 0, 0, 0, 1, 0));
        engine_push(8'h10, 0, 0); engine_push(8'h11, 0, 0);
        irq_check("R9 below level");
        engine_push(8'h12, 0, 0);
        irq_check("R9 at level");
        set_ctrl(cw(1, 1, 0, 1, 0, 0, 1));
        set_ctrl(cw(0, 1, 0, 0, 0, 0, 1));
        tx_write(8'h01); tx_write(8'h02);
        irq_check("R10 above level");
        set_ctrl(cw(1, 1, 0, 0, 0, 0, 1));
        engine_take("R10 drain");
        irq_check("R10 at level");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom_range(0, 11);
            case (op)
                0, 1, 2: tx_write(8'($urandom));
                3, 4:    engine_take("R2 random");
                5, 6:    engine_push(8'($urandom), ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
                7, 8:    rx_read("R4 random");
                9: begin
                    @(negedge clk); tx_shift_busy = 1'($urandom);
                    stat_check("R3 R5 R8 random status");
                end
                10: set_thr(8'($urandom_range(0, 70)), 8'($urandom_range(0, 70)));
                default: set_ctrl(cw(($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
                                     ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
                                     ($urandom_range(0, 11) == 0), 1'($urandom), 1'($urandom)));
            endcase
            irq_check("R9 R10 random irq");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule